// File: doc/BRIEF.md
# Raster to MCU Block Reorderer

This block sits in front of a DCT stage. It takes a 4:2:2 luma/chroma stream that arrives in raster order, one sample per beat, and hands it on in JPEG block order. Every input sample carries a component mark. The block gathers eight full lines, which form a stripe. It then walks the stripe in 16-pixel-wide MCUs. For each MCU it emits a left luma block, a right luma block, a blue-difference block and a red-difference block. Each block holds 64 samples in row-major order.

Two stripe banks let the next stripe be written while the current one is read out. The input uses a valid/ready handshake and is held off only when both banks hold complete stripes that are not yet drained. The output uses the same handshake, so the DCT stage can stall the stream. The image width is set in units of 16 pixels. It may change only while the block is idle. The height needs no setting: any number of stripes may follow one another.

Top module: `raster_mcu_reorder`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1.
- R2: The sample mark `inTag` selects the component: 0 is luma, 1 is blue-difference, 2 is red-difference. Each line may interleave the components in any order. It must carry W luma, W/2 blue and W/2 red samples, with W = 16 × `cfgMcuCols`. Each component is stored in its own arrival order.
- R3: Input lines arrive top to bottom, each with 2W samples. Every eight lines close one stripe.
- R4: MCU m of a stripe holds the following, all over the stripe's eight rows: luma columns 16m..16m+7 (left block), luma columns 16m+8..16m+15 (right block), and chroma columns 8m..8m+7 of each chroma component.
- R5: Within an MCU the blocks come out left luma, right luma, blue, red, and `outBlk` reads 0, 1, 2, 3 respectively.
- R6: Within a block, samples come out row by row from the top, each row left to right.
- R7: MCUs come out left to right across a stripe, and stripes come out in arrival order.
- R8: `outLast` is 1 on the 64th sample of every block and on no other sample.
- R9: The first sample of a stripe appears the cycle after that stripe's last input is accepted, or, if another stripe is being read out, as soon as that one is done. A stripe then streams with no gap except where `outReady` is low.
- R10: `inReady` is 0 exactly when two complete stripes are held and the older one has not been fully read from the banks.
- R11: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData`, `outBlk` and `outLast` hold their values into the next cycle.
- R12: `cfgMcuCols` may be any value from 1 to MAX_MCU_COLS and may be changed between frames while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMcuCols | input | CFG_W | Image width in 16-pixel units |
| inValid | input | 1 | Input sample present |
| inReady | output | 1 | Block can accept a sample |
| inTag | input | 2 | Component mark: 0 luma, 1 blue, 2 red |
| inData | input | DATA_W | Input sample |
| outValid | output | 1 | Output sample present |
| outReady | input | 1 | Downstream takes the sample |
| outData | output | DATA_W | Output sample |
| outBlk | output | 2 | Block kind: 0 left luma, 1 right luma, 2 blue, 3 red |
| outLast | output | 1 | Final sample of the current block |

## Verification
Four properties are checked on every cycle:
- the block-kind sequence Y1, Y2, U, V;
- `outLast` landing on every 64th accepted sample;
- the frozen output during a stall;
- the absence of gaps inside a stripe once its read-out has begun.

Other behaviour needs the bench's scenarios and its cycle-level model:
- whether the right pixel lands in the right block position for both chroma interleavings and several widths;
- the exact cycle the first stripe appears;
- the exact moment `inReady` falls when the downstream stalls long enough to fill both banks.

// File: rtl/mcu_reorder_pkg.sv
package mcu_reorder_pkg;

  typedef enum logic [1:0] {
    TAG_Y = 2'd0,
    TAG_U = 2'd1,
    TAG_V = 2'd2
  } sampleTag_e;

  typedef enum logic [1:0] {
    BLK_Y1 = 2'd0,
    BLK_Y2 = 2'd1,
    BLK_U  = 2'd2,
    BLK_V  = 2'd3
  } blkKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     wrEn;
    logic     rdEn;
    logic     outAdv;
    logic     rdLast;
    blkKind_e rdBlk;
  } ctrlStrobe_t;

endpackage

// File: rtl/mcu_reorder_ctrl.sv
module mcu_reorder_ctrl
  import mcu_reorder_pkg::*;
#(
  parameter int MAX_MCU_COLS = 4,
  localparam int MAX_W = 16 * MAX_MCU_COLS,
  localparam int STRIDE = 2 * MAX_W,
  localparam int BANK_DEPTH = 8 * STRIDE,
  localparam int ADDR_W = $clog2(2 * BANK_DEPTH),
  localparam int CFG_W = $clog2(MAX_MCU_COLS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  cfgMcuCols,
  input  logic              inValid,
  input  logic [1:0]        inTag,
  output logic              inReady,
  input  logic              outValid,
  input  logic              outReady,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam int LCOL_W = $clog2(MAX_W);
  localparam int CCOL_W = $clog2(MAX_W / 2);
  localparam int SCNT_W = $clog2(STRIDE);
  localparam int MCU_W = (MAX_MCU_COLS > 1) ? $clog2(MAX_MCU_COLS) : 1;

  logic [1:0] full, fullNext;

  // ---------------- write side ----------------
  logic              wBank;
  logic [2:0]        wLine;
  logic [LCOL_W-1:0] yCol;
  logic [CCOL_W-1:0] uCol, vCol;
  logic [SCNT_W-1:0] sCnt;
  logic [SCNT_W:0]   lineSamples;
  logic              accept, lastInLine, stripeIn;
  int                wOff;

  assign inReady     = !full[wBank];
  assign accept      = inValid && inReady;
  assign lineSamples = (SCNT_W + 1)'(cfgMcuCols) << 5;
  assign lastInLine  = ({1'b0, sCnt} == lineSamples - 1'b1);
  assign stripeIn    = accept && lastInLine && (wLine == 3'd7);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wBank <= 1'b0;
      wLine <= '0;
      yCol  <= '0;
      uCol  <= '0;
      vCol  <= '0;
      sCnt  <= '0;
    end else if (accept) begin
      if (lastInLine) begin
        yCol  <= '0;
        uCol  <= '0;
        vCol  <= '0;
        sCnt  <= '0;
        wLine <= wLine + 3'd1;
        if (wLine == 3'd7) wBank <= ~wBank;
      end else begin
        sCnt <= sCnt + 1'b1;
        if (inTag == TAG_Y)      yCol <= yCol + 1'b1;
        else if (inTag == TAG_U) uCol <= uCol + 1'b1;
        else                     vCol <= vCol + 1'b1;
      end
    end
  end

  always_comb begin
    if (inTag == TAG_Y)      wOff = int'(yCol);
    else if (inTag == TAG_U) wOff = MAX_W + int'(uCol);
    else                     wOff = MAX_W + MAX_W / 2 + int'(vCol);
    wrAddr = ADDR_W'(int'(wBank) * BANK_DEPTH + int'(wLine) * STRIDE + wOff);
  end

  // ---------------- read side ----------------
  logic             rBank;
  logic [MCU_W-1:0] rMcu;
  blkKind_e         rBlk;
  logic [2:0]       rRow, rCol;
  logic             adv, rdEn, blkEnd, stripeOut;
  int               rOff;

  assign adv       = !outValid || outReady;
  assign rdEn      = full[rBank] && adv;
  assign blkEnd    = (rRow == 3'd7) && (rCol == 3'd7);
  assign stripeOut = blkEnd && (rBlk == BLK_V) && (rMcu == MCU_W'(cfgMcuCols - 1'b1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rBank <= 1'b0;
      rMcu  <= '0;
      rBlk  <= BLK_Y1;
      rRow  <= '0;
      rCol  <= '0;
    end else if (rdEn) begin
      rCol <= rCol + 3'd1;
      if (rCol == 3'd7) rRow <= rRow + 3'd1;
      if (blkEnd) begin
        rBlk <= blkKind_e'(rBlk + 2'd1);
        if (rBlk == BLK_V) rMcu <= stripeOut ? '0 : rMcu + 1'b1;
      end
      if (stripeOut) rBank <= ~rBank;
    end
  end

  always_comb begin
    case (rBlk)
      BLK_Y1:  rOff = 16 * int'(rMcu) + int'(rCol);
      BLK_Y2:  rOff = 16 * int'(rMcu) + 8 + int'(rCol);
      BLK_U:   rOff = MAX_W + 8 * int'(rMcu) + int'(rCol);
      default: rOff = MAX_W + MAX_W / 2 + 8 * int'(rMcu) + int'(rCol);
    endcase
    rdAddr = ADDR_W'(int'(rBank) * BANK_DEPTH + int'(rRow) * STRIDE + rOff);
  end

  // ---------------- bank occupancy ----------------
  always_comb begin
    fullNext = full;
    if (stripeIn) fullNext[wBank] = 1'b1;
    if (rdEn && stripeOut) fullNext[rBank] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) full <= '0;
    else       full <= fullNext;
  end

  assign strobe.wrEn   = accept;
  assign strobe.rdEn   = rdEn;
  assign strobe.outAdv = adv;
  assign strobe.rdLast = blkEnd;
  assign strobe.rdBlk  = rBlk;

endmodule

// File: rtl/mcu_reorder_dp.sv
module mcu_reorder_dp
  import mcu_reorder_pkg::*;
#(
  parameter int MAX_MCU_COLS = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 2 * 8 * 2 * 16 * MAX_MCU_COLS,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outBlk,
  output logic              outLast
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.rdEn) begin
      outData <= mem[rdAddr];
      outBlk  <= strobe.rdBlk;
      outLast <= strobe.rdLast;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              outValid <= 1'b0;
    else if (strobe.outAdv) outValid <= strobe.rdEn;
  end

endmodule

// File: rtl/raster_mcu_reorder.sv
module raster_mcu_reorder
  import mcu_reorder_pkg::*;
#(
  parameter int MAX_MCU_COLS = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(2 * 8 * 2 * 16 * MAX_MCU_COLS),
  localparam int CFG_W = $clog2(MAX_MCU_COLS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  cfgMcuCols,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inTag,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outBlk,
  output logic              outLast
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  mcu_reorder_ctrl #(.MAX_MCU_COLS(MAX_MCU_COLS)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgMcuCols(cfgMcuCols),
    .inValid(inValid), .inTag(inTag), .inReady(inReady),
    .outValid(outValid), .outReady(outReady),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  mcu_reorder_dp #(.MAX_MCU_COLS(MAX_MCU_COLS), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(inData), .rdAddr(rdAddr),
    .outValid(outValid), .outData(outData), .outBlk(outBlk), .outLast(outLast)
  );

endmodule

// File: rtl/mcu_reorder_chk.sv
module mcu_reorder_chk #(
  parameter int DATA_W = 8,
  parameter int CFG_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [CFG_W-1:0]  cfgMcuCols,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic [1:0]        outBlk,
  input logic              outLast
);

  logic [5:0]       sampleInBlk;
  logic [1:0]       expBlk;
  logic [CFG_W+1:0] blkInStripe;
  logic [CFG_W+1:0] lastBlkIdx;
  logic             fire, stripeEndNow;

  assign fire         = outValid && outReady;
  assign lastBlkIdx   = {cfgMcuCols, 2'b00} - 1'b1;
  assign stripeEndNow = outLast && (blkInStripe == lastBlkIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleInBlk <= '0;
      expBlk      <= '0;
      blkInStripe <= '0;
    end else if (fire) begin
      sampleInBlk <= sampleInBlk + 6'd1;
      if (outLast) begin
        expBlk      <= expBlk + 2'd1;
        blkInStripe <= (blkInStripe == lastBlkIdx) ? '0 : blkInStripe + 1'b1;
      end
    end
  end

  // R8: marker on every 64th accepted sample only
  assert_last_on_64th_R8: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (outLast == (sampleInBlk == 6'd63)));

  // R5: block kinds cycle Y1, Y2, U, V
  assert_block_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outBlk == expBlk));

  // R11: output frozen while stalled
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outBlk) && $stable(outLast)));

  // R9: no bubble inside a stripe
  assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !stripeEndNow) |=> outValid);

endmodule

bind raster_mcu_reorder mcu_reorder_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgMcuCols(cfgMcuCols),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outBlk(outBlk), .outLast(outLast)
);

// File: tb/tb_raster_mcu_reorder.sv
module tb_raster_mcu_reorder;

  localparam int MAXC = 4;
  localparam int DW = 8;
  localparam int CW = $clog2(MAXC + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] cfgMcuCols = CW'(1);
  logic          inValid = 1'b0;
  logic          inReady;
  logic [1:0]    inTag = 2'd0;
  logic [DW-1:0] inData = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [DW-1:0] outData;
  logic [1:0]    outBlk;
  logic          outLast;

  always #4 clk = ~clk;

  raster_mcu_reorder #(.MAX_MCU_COLS(MAXC), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .cfgMcuCols(cfgMcuCols),
    .inValid(inValid), .inReady(inReady), .inTag(inTag), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outBlk(outBlk), .outLast(outLast)
  );

  int nCmp = 0, nFail = 0, cyc = 0;
  bit timedOut = 0;

  // reference model state
  int inData_q[$], inTag_q[$];
  int expData[$], expBlk[$], expLast[$];
  int stripeLen, acc, issued, compPrev, mIdx;
  bit mValid, rdyDrv, sawStall;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int pix(int x, int y, int comp, int salt);
    return (x * 5 + y * 29 + comp * 71 + salt) % 256;
  endfunction

  // one clock: model the edge just passed, compare, then drive the next beat
  task automatic tick(input int gapPct, input int rdyPct, input bit stallNow);
    int compNow;
    @(negedge clk);
    cyc++;
    if (!mValid || rdyDrv) begin
      if (issued < compPrev * stripeLen) begin
        mValid = 1'b1; mIdx = issued; issued++;
      end else mValid = 1'b0;
    end
    compNow = acc / stripeLen;
    chk(outValid == mValid, "R9 valid", int'(outValid), int'(mValid));
    if (mValid && outValid) begin
      chk(outData == DW'(expData[mIdx]), "R4/R6/R7 data", int'(outData), expData[mIdx]);
      chk(outBlk == 2'(expBlk[mIdx]), "R5 blk", int'(outBlk), expBlk[mIdx]);
      chk(outLast == expLast[mIdx][0], "R8 last", int'(outLast), expLast[mIdx]);
    end
    chk(inReady == ((compNow - issued / stripeLen) < 2), "R10 ready",
        int'(inReady), int'((compNow - issued / stripeLen) < 2));
    if (!inReady) sawStall = 1'b1;
    compPrev = compNow;
    rdyDrv = stallNow ? 1'b0 : ($urandom_range(99) < rdyPct);
    outReady = rdyDrv;
    if (inData_q.size() > 0 && $urandom_range(99) >= gapPct) begin
      inValid = 1'b1;
      inData = DW'(inData_q[0]);
      inTag = 2'(inTag_q[0]);
      if (inReady) begin
        void'(inData_q.pop_front());
        void'(inTag_q.pop_front());
        acc++;
      end
    end else inValid = 1'b0;
  endtask

  // yuyvOrder=0: U Y V Y per pixel pair, 1: Y U Y V (R2)
  task automatic runScenario(input int cols, input bit yuyvOrder, input int nStripes,
                             input int salt, input int gapPct, input int rdyPct,
                             input int stallCycles);
    int w, total, start;
    w = 16 * cols;
    cfgMcuCols = CW'(cols);   // R12: width changed while idle
    stripeLen = 256 * cols;
    acc = 0; issued = 0; compPrev = 0; mValid = 1'b0;
    inData_q.delete(); inTag_q.delete();
    expData.delete(); expBlk.delete(); expLast.delete();
    for (int s = 0; s < nStripes; s++) begin
      for (int r = 0; r < 8; r++) begin   // R3: raster lines of 2W samples
        for (int p = 0; p < w / 2; p++) begin
          int y = 8 * s + r;
          if (yuyvOrder) begin
            inTag_q.push_back(0); inData_q.push_back(pix(2 * p, y, 0, salt));
            inTag_q.push_back(1); inData_q.push_back(pix(p, y, 1, salt));
            inTag_q.push_back(0); inData_q.push_back(pix(2 * p + 1, y, 0, salt));
            inTag_q.push_back(2); inData_q.push_back(pix(p, y, 2, salt));
          end else begin
            inTag_q.push_back(1); inData_q.push_back(pix(p, y, 1, salt));
            inTag_q.push_back(0); inData_q.push_back(pix(2 * p, y, 0, salt));
            inTag_q.push_back(2); inData_q.push_back(pix(p, y, 2, salt));
            inTag_q.push_back(0); inData_q.push_back(pix(2 * p + 1, y, 0, salt));
          end
        end
      end
      for (int m = 0; m < cols; m++)
        for (int b = 0; b < 4; b++)
          for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
              int x = (b == 0) ? 16 * m + c : (b == 1) ? 16 * m + 8 + c : 8 * m + c;
              int comp = (b < 2) ? 0 : b - 1;
              expData.push_back(pix(x, 8 * s + r, comp, salt));
              expBlk.push_back(b);
              expLast.push_back(int'(r == 7 && c == 7));
            end
    end
    total = expData.size();
    start = cyc;
    while (!(issued == total && !mValid && inData_q.size() == 0)) begin
      tick(gapPct, rdyPct, (cyc - start) < stallCycles);
      if (cyc > 150000) begin
        timedOut = 1'b1;
        break;
      end
    end
    chk(issued == total, "R7 stripe count", issued, total);
  endtask

  initial begin
    stripeLen = 256; acc = 0; issued = 0; compPrev = 0; mValid = 0; rdyDrv = 1; sawStall = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    chk(inReady == 1'b1, "R1 inReady", int'(inReady), 1);

    // R2/R4 with U-first interleave, full rate both sides
    if (!timedOut) runScenario(2, 1'b0, 2, 3, 0, 100, 0);
    // R2 Y-first interleave, single MCU width, random gaps and stalls
    if (!timedOut) runScenario(1, 1'b1, 3, 11, 30, 50, 0);
    // R10: long downstream stall at maximum width fills both banks
    sawStall = 1'b0;
    if (!timedOut) runScenario(MAXC, 1'b0, 3, 40, 0, 100, 2500);
    chk(sawStall, "R10 backpressure seen", int'(sawStall), 1);
    // R12: non power-of-two width
    if (!timedOut) runScenario(3, 1'b1, 2, 77, 10, 80, 0);

    if (timedOut) begin
      nCmp++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nFail);
    $finish;
  end

endmodule